// File: doc/BRIEF.md
# Framebuffer scan-out address generator

This block reads a true-colour frame out of memory for a fixed-resolution panel. Software gives it a frame base address and a control word carrying an enable bit and a half-turn rotation bit. An external timing source marks the start of each frame and strobes once per visible pixel. The block then walks the visible raster and issues one word read per pixel. It keeps the returned word in a one-entry buffer and shows it on the red, green and blue outputs at the next pixel strobe.

Memory is laid out with a fixed row pitch that is wider than the visible line. Only the visible words of each row are fetched. The base address is honoured only in its upper bits, so a frame always starts on a coarse aligned boundary. Register writes are held in shadow copies and take effect at the next frame start, so a frame is never torn mid-scan. The default geometry is 640 visible pixels, 480 rows and a 1024-word row pitch, with the top 11 base bits kept; all of these are parameters.

Top module: `fb_scanout`

## Requirements
- R1: After reset the display is disabled with a zero base. rd_req is 0, red, green and blue are 0, and underrun is 0. A frame start with no prior register write leaves the display disabled.
- R2: A write with reg_sel=0 sets the base. Only reg_wdata[31:21] are kept and the lower address bits are taken as zero. A write with reg_sel=1 sets control, where bit 0 is enable and bit 1 is rotate. Either write takes effect only at the next frame_start.
- R3: The read address for the pixel at (row, col) is base + ((row*1024 + col)*4). Only columns 0 to 639 of each row are read.
- R4: With rotate off, reads go in order from row 0 col 0: the column counts up and then the row counts up.
- R5: With rotate on, reads go in order from row 479 col 639: the column counts down and then the row counts down.
- R6: On a pixel strobe with a word buffered, the outputs become red = word[23:16], green = word[15:8] and blue = word[7:0]. Bits 31:24 are ignored. The outputs do not change without a strobe or frame start.
- R7: rd_req is a one-cycle pulse. At most one read is outstanding. After a frame start that enables the display, the first read is issued, and each consumed pixel triggers the read for the next one. Exactly one read is issued per visible pixel per frame, and none after the last.
- R8: A pixel strobe that finds no word buffered leaves the outputs unchanged and sets underrun. underrun stays set until the next frame_start.
- R9: While disabled the block issues no reads, shows black and ignores pixel strobes. Writing 0 to control turns the display off from the next frame.
- R10: A frame_start in the middle of a frame restarts the scan at the first pixel and clears the outputs to black. The buffered word is discarded, and so is the response to any read still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects base, 1 selects control |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle frame start pulse |
| pix_adv | input | 1 | One-cycle pixel advance strobe |
| rd_req | output | 1 | Word read request, one cycle |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |
| underrun | output | 1 | Sticky per-frame underrun flag |

## Verification
The assertions check several properties on every cycle. Each read request lasts one cycle and its address stays inside the aligned frame window. The raster counters stay inside the visible area. The active configuration moves only at a frame start. The pixel outputs hold between strobes, and underrun rises only after a strobe that found the buffer empty. The bench scenarios are needed to show the rest: the exact address sequence in both scan orders, the correct unpacking of the returned words, the dropping of a stale response after a mid-frame restart, and the end-of-frame stop. The bench uses a scaled-down geometry so that whole frames fit in the run.

// File: rtl/fb_pkg.sv
// Shared types and register encodings for the scan-out block.
// Assumes 32-bit registers and byte addresses.
package fb_pkg;
    localparam int REG_W    = 32;
    localparam int CTRL_EN  = 0;   // control bit: display enable
    localparam int CTRL_ROT = 1;   // control bit: half-turn rotation
    localparam logic SEL_BASE = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    typedef struct packed {
        logic             en;
        logic             rot;
        logic [REG_W-1:0] base;
    } fb_cfg_t;
endpackage

// File: rtl/fb_cfg_regs.sv
// Shadow and active copies of the base and control registers.
// A write lands in the shadow copy. The active copy follows it only on load,
// which is the frame start. Only the top BASE_KEEP base bits are stored.
module fb_cfg_regs
    import fb_pkg::*;
#(
    parameter int BASE_KEEP = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             load,
    output fb_cfg_t          shadow,
    output fb_cfg_t          active
);
    localparam int LOW_W = REG_W - BASE_KEEP;

    fb_cfg_t shadow_q;
    fb_cfg_t active_q;
    logic    unused_bits;

    // Capture software writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) begin
                shadow_q.en  <= wr_data[CTRL_EN];
                shadow_q.rot <= wr_data[CTRL_ROT];
            end else begin
                shadow_q.base <= {wr_data[REG_W-1 -: BASE_KEEP], LOW_W'(0)};
            end
        end
    end

    // Move the shadow copy into use at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)    active_q <= '0;
        else if (load) active_q <= shadow_q;
    end

    assign unused_bits = ^wr_data[LOW_W-1:2];
    assign shadow      = shadow_q;
    assign active      = active_q;

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active_q));
endmodule

// File: rtl/fb_raster.sv
// Raster position counter over the visible area.
// Counts forward from the top-left or backward from the bottom-right.
// Holds at the final pixel and never leaves the visible area.
module fb_raster #(
    parameter int H_PIX  = 640,
    parameter int V_ROWS = 480,
    localparam int COL_W = $clog2(H_PIX),
    localparam int ROW_W = $clog2(V_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             rot_restart,
    input  logic             rot_run,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             last
);
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(H_PIX - 1);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(V_ROWS - 1);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;

    // Move to the start corner on restart, then step one pixel at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (restart) begin
            col_q <= rot_restart ? COL_MAX : '0;
            row_q <= rot_restart ? ROW_MAX : '0;
        end else if (step && !last) begin
            if (!rot_run) begin
                if (col_q == COL_MAX) begin
                    col_q <= '0;
                    row_q <= row_q + ROW_W'(1);
                end else begin
                    col_q <= col_q + COL_W'(1);
                end
            end else begin
                if (col_q == '0) begin
                    col_q <= COL_MAX;
                    row_q <= row_q - ROW_W'(1);
                end else begin
                    col_q <= col_q - COL_W'(1);
                end
            end
        end
    end

    assign last = rot_run ? (row_q == '0 && col_q == '0)
                          : (row_q == ROW_MAX && col_q == COL_MAX);
    assign col  = col_q;
    assign row  = row_q;

    assert_in_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q <= COL_MAX) && (row_q <= ROW_MAX));
endmodule

// File: rtl/fb_pixel_path.sv
// Fetch control and pixel hold for the scan-out block.
// Keeps at most one read outstanding and a one-word buffer. A pixel strobe
// moves the buffered word to the outputs, or flags an underrun if none is there.
// A read that is still outstanding at frame start is marked stale, and its
// response is dropped.
module fb_pixel_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic              en_next,
    input  logic              en,
    input  logic              adv,
    input  logic              last_pix,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              req,
    output logic              step,
    output logic [7:0]        pix_r,
    output logic [7:0]        pix_g,
    output logic [7:0]        pix_b,
    output logic              underrun
);
    localparam int CHANS = 3;

    logic        want_q, pend_q, stale_q, done_q, buf_v_q, under_q;
    logic [23:0] buf_q, pix_q;
    logic        pend_n, consume;
    logic [7:0]  chan [CHANS];
    logic        unused_top;

    assign req     = en && want_q && !pend_q;
    assign pend_n  = (pend_q && !rsp_valid) || req;
    assign consume = adv && en && !done_q && buf_v_q && !frame_go;
    assign step    = consume;

    // Track requests, responses and pixel consumption for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q  <= 1'b0;
            pend_q  <= 1'b0;
            stale_q <= 1'b0;
            done_q  <= 1'b0;
            buf_v_q <= 1'b0;
            under_q <= 1'b0;
            buf_q   <= '0;
            pix_q   <= '0;
        end else if (frame_go) begin
            want_q  <= en_next;
            pend_q  <= pend_n;
            stale_q <= pend_n;
            done_q  <= 1'b0;
            buf_v_q <= 1'b0;
            under_q <= 1'b0;
            pix_q   <= '0;
        end else begin
            pend_q <= pend_n;
            if (rsp_valid && stale_q) stale_q <= 1'b0;
            if (req) want_q <= 1'b0;
            if (consume) begin
                pix_q   <= buf_q;
                buf_v_q <= 1'b0;
                if (last_pix) done_q <= 1'b1;
                else          want_q <= 1'b1;
            end else if (rsp_valid && !stale_q && en) begin
                buf_v_q <= 1'b1;
                buf_q   <= rsp_data[23:0];
            end
            if (adv && en && !done_q && !buf_v_q) under_q <= 1'b1;
        end
    end

    // Split the held word into its colour channels, black while disabled.
    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        assign chan[c] = en ? pix_q[8*c +: 8] : 8'h00;
    end

    assign pix_b      = chan[0];
    assign pix_g      = chan[1];
    assign pix_r      = chan[2];
    assign underrun   = under_q;
    assign unused_top = ^rsp_data[DATA_W-1:24];

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(under_q) |-> ($past(adv) && !$past(buf_v_q)));
    assert_pixel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !frame_go) |=> $stable(pix_q));
endmodule

// File: rtl/fb_scanout.sv
// Framebuffer scan-out address generator, top level.
// Assumes: frame_start and pix_adv are one-cycle pulses from an outside timing
// source, memory answers each read with exactly one rd_valid at least one
// cycle later, and H_PIX <= ROW_WORDS with ROW_WORDS a power of two.
module fb_scanout
    import fb_pkg::*;
#(
    parameter int H_PIX     = 640,
    parameter int V_ROWS    = 480,
    parameter int ROW_WORDS = 1024,
    parameter int BASE_KEEP = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        frame_start,
    input  logic        pix_adv,
    output logic        rd_req,
    output logic [31:0] rd_addr,
    input  logic        rd_valid,
    input  logic [31:0] rd_data,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue,
    output logic        underrun
);
    localparam int COL_W = $clog2(H_PIX);
    localparam int ROW_W = $clog2(V_ROWS);
    localparam int STR_W = $clog2(ROW_WORDS);
    localparam int OFF_W = ROW_W + STR_W;

    fb_cfg_t          cfg_sh, cfg_act;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             last_pix, step;
    logic [OFF_W-1:0] word_off;

    fb_cfg_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_sel(reg_sel),
        .wr_data(reg_wdata), .load(frame_start),
        .shadow(cfg_sh), .active(cfg_act)
    );

    fb_raster #(.H_PIX(H_PIX), .V_ROWS(V_ROWS)) u_raster (
        .clk(clk), .rst_n(rst_n), .restart(frame_start),
        .rot_restart(cfg_sh.rot), .rot_run(cfg_act.rot), .step(step),
        .col(col), .row(row), .last(last_pix)
    );

    fb_pixel_path #(.DATA_W(REG_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_start),
        .en_next(cfg_sh.en), .en(cfg_act.en), .adv(pix_adv),
        .last_pix(last_pix), .rsp_valid(rd_valid), .rsp_data(rd_data),
        .req(rd_req), .step(step),
        .pix_r(red), .pix_g(green), .pix_b(blue), .underrun(underrun)
    );

    // Word offset inside the frame: row times the pitch, plus the column.
    assign word_off = (OFF_W'(row) << STR_W) | OFF_W'(col);
    assign rd_addr  = cfg_act.base + (REG_W'(word_off) << 2);

    assert_addr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[REG_W-1 -: BASE_KEEP] == cfg_act.base[REG_W-1 -: BASE_KEEP]));
endmodule

// File: tb/fb_scanout_bench.sv
module fb_scanout_bench;
    localparam int H = 12, V = 5, S = 16, N = H * V;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        frame_start = 1'b0, pix_adv = 1'b0, rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    wire         rd_req, underrun;
    wire  [31:0] rd_addr;
    wire  [7:0]  red, green, blue;

    always #5 clk = ~clk;

    fb_scanout #(.H_PIX(H), .V_ROWS(V), .ROW_WORDS(S), .BASE_KEEP(11)) u_fb_scanout (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .pix_adv(pix_adv),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .red(red), .green(green), .blue(blue), .underrun(underrun)
    );

    int total = 0, bad = 0;
    // expected-state model, from the requirements
    bit sh_en, sh_rot, m_en, m_rot, m_buf, m_under, m_done, m_stale, m_busy;
    logic [31:0] sh_base, m_base, mem_addr, q_wd, q_data;
    logic [23:0] m_word, m_pix;
    int m_k, m_rq, mem_cnt, lat_max = 2;
    bit q_we, q_sel, q_fs, q_adv, q_valid, q_req, q_rst = 1'b1;

    function automatic logic [31:0] exp_addr(logic [31:0] b, bit rot, int k);
        int j, r, c;
        j = rot ? (N - 1 - k) : k;
        r = j / H;
        c = j % H;
        return b + 32'((r * S + c) * 4);
    endfunction

    function automatic logic [31:0] word_at(logic [31:0] a);
        return {8'hEE, a[11:4], a[9:2] ^ 8'hA5, a[5:2], a[13:10]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Apply the clock edge that has just passed to the model.
    task automatic model_edge();
        bit busy_n, loaded;
        if (q_rst) begin
            {sh_en, sh_rot, m_en, m_rot, m_buf, m_under, m_done, m_stale, m_busy} = '0;
            sh_base = '0; m_base = '0; m_pix = '0; m_word = '0; m_k = 0; m_rq = 0;
        end else begin
            busy_n = (m_busy && !q_valid) || q_req;
            if (q_fs) begin
                m_en = sh_en; m_rot = sh_rot; m_base = sh_base;
                m_buf = 0; m_pix = '0; m_under = 0; m_done = 0;
                m_k = 0; m_rq = 0; m_stale = busy_n;
            end else begin
                loaded = q_valid && !m_stale && m_en;
                if (q_valid && m_stale) m_stale = 0;
                if (q_adv && m_en && !m_done) begin
                    if (m_buf) begin
                        m_pix = m_word; m_buf = 0; m_k++;
                        if (m_k == N) m_done = 1;
                    end else m_under = 1;
                end
                if (loaded) begin m_buf = 1; m_word = q_data[23:0]; end
            end
            m_busy = busy_n;
            if (q_we) begin
                if (q_sel) {sh_rot, sh_en} = q_wd[1:0];
                else sh_base = {q_wd[31:21], 21'b0};
            end
        end
    endtask

    task automatic cyc(input bit adv, input bit fs, input bit we = 0, input bit sel = 0,
                       input logic [31:0] wd = '0, input bit rst = 0);
        logic [31:0] ea;
        @(negedge clk);
        model_edge();
        // R6 R9 R10: pixel outputs; R8: underrun flag
        chk({red, green, blue} == (m_en ? m_pix : 24'h0), m_en ? "R6 R10" : "R9",
            {8'h0, red, green, blue}, {8'h0, (m_en ? m_pix : 24'h0)});
        chk(underrun == m_under, "R8", 32'(underrun), 32'(m_under));
        // memory model
        rd_valid = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin rd_valid = 1'b1; rd_data = word_at(mem_addr); end
        end
        q_req = rd_req;
        if (rd_req) begin
            chk(m_en, "R9", 32'(rd_req), 32'h0);
            chk(!m_busy && mem_cnt == 0, "R7", 32'(m_busy), 32'h0);
            chk(m_rq < N, "R7", 32'(m_rq), 32'(N - 1));
            ea = exp_addr(m_base, m_rot, m_rq);
            chk(rd_addr == ea, m_rot ? "R2 R3 R5" : "R2 R3 R4", rd_addr, ea);
            m_rq++;
            mem_addr = rd_addr;
            mem_cnt = $urandom_range(lat_max, 1);
        end
        q_valid = rd_valid; q_data = rd_data;
        pix_adv = adv; frame_start = fs; reg_we = we; reg_sel = sel; reg_wdata = wd;
        rst_n = !rst;
        q_adv = adv; q_fs = fs; q_we = we; q_sel = sel; q_wd = wd; q_rst = rst;
    endtask

    task automatic run_frame(input int gap);
        cyc(0, 1);
        for (int k = 0; k < N + 3; k++) begin
            repeat (gap) cyc(0, 0);
            cyc(1, 0);
        end
        repeat (6) cyc(0, 0);
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) cyc(0, 0, 0, 0, '0, 1);
        cyc(0, 0);
        // R1: reset state
        chk(!rd_req && {red, green, blue} == 24'h0 && !underrun, "R1",
            {7'h0, rd_req, red, green, blue}, 32'h0);
        // R1 R9: frame start with no writes stays disabled
        cyc(0, 1);
        repeat (20) cyc(1'($urandom_range(1, 0)), 0);
        chk(m_rq == 0, "R1", 32'(m_rq), 32'h0);
        // R2: writes are shadowed until the next frame start
        cyc(0, 0, 1, 0, 32'h1234_5678);
        cyc(0, 0, 1, 1, 32'h0000_0001);
        repeat (8) cyc(1, 0);
        chk(m_rq == 0, "R2", 32'(m_rq), 32'h0);
        // R4 R6 R7: full forward frame, no underrun
        lat_max = 3;
        run_frame(5);
        chk(m_rq == N, "R7", 32'(m_rq), 32'(N));
        chk(!underrun, "R8", 32'(underrun), 32'h0);
        // R5: full rotated frame with another base
        cyc(0, 0, 1, 0, 32'hA5E0_0FFC);
        cyc(0, 0, 1, 1, 32'h0000_0003);
        run_frame(5);
        chk(m_rq == N, "R7", 32'(m_rq), 32'(N));
        // R8: strobe straight after frame start finds no word
        lat_max = 4;
        cyc(0, 1);
        cyc(1, 0);
        cyc(0, 0);
        chk(underrun == 1'b1, "R8", 32'(underrun), 32'h1);
        repeat (30) cyc(1'($urandom_range(1, 0)), 0);
        // R10: restart while a read is outstanding
        do cyc(0, 0); while (!q_req);
        cyc(0, 1);
        for (int k = 0; k < 8; k++) begin repeat (6) cyc(0, 0); cyc(1, 0); end
        // random frames with mid-frame restarts
        for (int f = 0; f < 6; f++) begin
            cyc(0, 0, 1, 0, $urandom());
            cyc(0, 0, 1, 1, {30'($urandom()), 1'($urandom_range(1, 0)), 1'b1});
            cyc(0, 1);
            for (int i = 0; i < 160; i++) cyc($urandom_range(2, 0) == 0, 0);
        end
        // R9: writing zero to control turns the display off at the next frame
        cyc(0, 0, 1, 1, 32'h0);
        cyc(0, 1);
        repeat (20) cyc(1, 0);
        chk({red, green, blue} == 24'h0 && m_rq == 0, "R9", {8'h0, red, green, blue}, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R7 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule